// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between bus-master I/O devices and memory and turns 32-bit device DMA addresses into 31-bit physical addresses. A configurable window, always ending at address 0xFFFFFFFF, is mapped through a single-level page table in memory. The table is indexed by 4 KB page, and its start address is held in a base register. An 8-entry fully associative TLB caches entries. On a miss, the block fetches one table word over a read-request/response port.

Each device slot can be set to bypass translation. A bypassed slot's address passes straight through, and a per-slot configuration pin supplies physical bit 30. Software controls the block through a small register port. Through it, software enables translation, picks the window size, sets the table base, and invalidates cached entries, either all at once or one page at a time. Accesses outside the window, accesses to invalid entries and writes to read-only entries return a fault instead of an address.

Requests and responses are valid/ready streams. A request is taken only when the unit is idle, so one translation is in flight at a time. A response holds its value until the consumer raises `rsp_ready`. The table-fetch request holds its address until `mem_req_ready` is seen. The fetch response is a single-cycle pulse that the unit always accepts.

Top module: `dma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, translation is disabled, the window code is 0 and the table base reads 0.
- R2: Register selector 0 is control: bit 0 enables translation, bits 4:2 hold the window code, bits 31:28 read the fixed implementation code, bits 27:24 read the fixed version code, and all other bits read 0. Selector 1 is the table base (32 bits). Selectors 2 and 3 are the write-only flush registers and read 0.
- R3: Window code k places the window start at 0xFF000000 shifted left by k (k=0 gives 16 MB, k=7 gives 2 GB). A non-bypass address below the start faults and produces no table fetch.
- R4: With the enable bit clear, every non-bypass request faults with no table fetch, even for pages held in the TLB.
- R5: A request from a slot whose `slot_bypass` bit is set returns `{slot_pa30[slot], vaddr[29:0]}` without a fault and without a table fetch, whatever the enable and window settings.
- R6: On a TLB miss inside an enabled window, exactly one word is read at `base + ((vaddr - start) >> 12) * 4`. A usable entry gives the physical address `{pte[26:8], vaddr[11:0]}`.
- R7: An entry with bit 1 (valid) clear, or a write request to an entry with bit 2 (writeable) clear, produces a fault response with `rsp_paddr` equal to 0. A fetched entry that faults is not cached. A write that hits a cached read-only entry also faults.
- R8: A request to a page already cached completes with no table fetch.
- R9: The TLB holds 8 entries. Installs fill them in round-robin order, so the ninth distinct page replaces the first one installed.
- R10: A write of any value to selector 2 invalidates every TLB entry.
- R11: A write to selector 3 invalidates only the entry whose page matches bits 31:12 of the written value. Bits 11:0 are ignored.
- R12: A flush write that arrives while a table fetch is outstanding still lets that request receive its translated address, but the fetched entry is not cached.
- R13: Only one request is in flight: `req_ready` is 0 while a fetch or response is pending. `rsp_valid` with its data holds until `rsp_ready`. `mem_req_valid` with its address holds until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| slot_bypass | input | 4 | Per-slot bypass enable |
| slot_pa30 | input | 4 | Per-slot physical bit 30 used in bypass |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can take a request |
| req_vaddr | input | 32 | Device DMA address |
| req_write | input | 1 | Request is a write |
| req_slot | input | 2 | Requesting device slot |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 31 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Table fetch request valid |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_addr | output | 32 | Table word address |
| mem_rsp_valid | input | 1 | Table word returned (one-cycle pulse) |
| mem_rsp_data | input | 32 | Returned table word |

## Verification
The bench targets several corner cases. A flush landing during an outstanding fetch: a design that cached the result anyway would skip the next fetch for that page. A write hitting a cached read-only entry: a design checking permission only on fetch would hand out an address. An eviction after eight installs: a wrong replacement order would fetch or hit on the wrong page. A page flush with nonzero low bits: a wrong compare would leave the entry live or clear its neighbours. It also changes window size and enable with live TLB contents, and drives bypass slots with both values of bit 30, where a wrong bit selection or a wrong ordering of bypass against the enable check shows up in the returned address or fault.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 31;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  // register selectors
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_BASE  = 3'd1;
  localparam logic [2:0] SEL_FLALL = 3'd2;
  localparam logic [2:0] SEL_FLPG  = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_MWAIT, S_RESP} xl_state_e;

  // first address of the translated window for a size code
  function automatic logic [VA_W-1:0] win_start(input logic [2:0] code);
    return 32'hFF00_0000 << code;
  endfunction
endpackage

// File: rtl/xlate_regs.sv
`timescale 1ns/1ps
module xlate_regs
  import xlate_pkg::*;
#(
  parameter logic [3:0] IMPL_CODE = 4'h1,
  parameter logic [3:0] VERS_CODE = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              xl_en,
  output logic [2:0]        win_code,
  output logic [31:0]       tbl_base,
  output logic              flush_all,
  output logic              flush_page,
  output logic [VPN_W-1:0]  flush_vpn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_en    <= 1'b0;
      win_code <= 3'd0;
      tbl_base <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        xl_en    <= wdata[0];
        win_code <= wdata[4:2];
      end
      if (sel == SEL_BASE) tbl_base <= wdata;
    end
  end

  assign flush_all  = wr_en && (sel == SEL_FLALL);
  assign flush_page = wr_en && (sel == SEL_FLPG);
  assign flush_vpn  = wdata[VA_W-1:OFF_W];

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = {IMPL_CODE, VERS_CODE, 19'b0, win_code, 1'b0, xl_en};
      SEL_BASE: rdata = tbl_base;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlate_tlb.sv
`timescale 1ns/1ps
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lookup_vpn,
  output logic              hit,
  output logic [PPN_W-1:0]  hit_ppn,
  output logic              hit_wr,
  input  logic              install,
  input  logic [VPN_W-1:0]  install_vpn,
  input  logic [PPN_W-1:0]  install_ppn,
  input  logic              install_wr,
  input  logic              flush_all,
  input  logic              flush_page,
  input  logic [VPN_W-1:0]  flush_vpn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] wr_q, valid_q, hit_vec;
  logic [PTR_W-1:0] rr_q;
  logic do_install;

  // a flush in the same cycle wins over an install
  assign do_install = install && !flush_all &&
                      !(flush_page && (flush_vpn == install_vpn));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (flush_all || (flush_page && tag_q[e] == flush_vpn))
          valid_q[e] <= 1'b0;
        else if (do_install && rr_q == PTR_W'(e))
          valid_q[e] <= 1'b1;
      end
      if (do_install)
        rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (do_install && rr_q == PTR_W'(e)) begin
        tag_q[e] <= install_vpn;
        ppn_q[e] <= install_ppn;
        wr_q[e]  <= install_wr;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == lookup_vpn);
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    hit_wr  = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e]) begin
        hit_ppn = hit_ppn | ppn_q[e];
        hit_wr  = hit_wr | wr_q[e];
      end
    end
  end
  assign hit = |hit_vec;

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));
endmodule

// File: rtl/dma_xlate.sv
`timescale 1ns/1ps
module dma_xlate
  import xlate_pkg::*;
#(
  parameter int         NUM_SLOTS   = 4,
  parameter int         TLB_ENTRIES = 8,
  parameter logic [3:0] IMPL_CODE   = 4'h1,
  parameter logic [3:0] VERS_CODE   = 4'h2,
  localparam int        SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SLOTS-1:0] slot_bypass,
  input  logic [NUM_SLOTS-1:0] slot_pa30,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_vaddr,
  input  logic                 req_write,
  input  logic [SLOT_W-1:0]    req_slot,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [30:0]          rsp_paddr,
  output logic                 rsp_fault,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [31:0]          mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data
);
  logic              xl_en, flush_all, flush_page;
  logic [2:0]        win_code;
  logic [31:0]       tbl_base;
  logic [VPN_W-1:0]  flush_vpn;
  logic              tlb_hit, tlb_hit_wr;
  logic [PPN_W-1:0]  tlb_hit_ppn;
  logic              install;

  xl_state_e         state_q;
  logic [31:0]       va_q, walk_addr_q;
  logic              wr_q, kill_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;

  xlate_regs #(.IMPL_CODE(IMPL_CODE), .VERS_CODE(VERS_CODE)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .xl_en(xl_en),
    .win_code(win_code), .tbl_base(tbl_base), .flush_all(flush_all),
    .flush_page(flush_page), .flush_vpn(flush_vpn));

  // entry decode of the returned table word
  logic              pte_ok;
  assign pte_ok  = mem_rsp_data[1] && !(wr_q && !mem_rsp_data[2]);
  assign install = (state_q == S_MWAIT) && mem_rsp_valid && pte_ok &&
                   !kill_q && !flush_all && !flush_page;

  xlate_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
    .clk(clk), .rst_n(rst_n), .lookup_vpn(req_vaddr[VA_W-1:OFF_W]),
    .hit(tlb_hit), .hit_ppn(tlb_hit_ppn), .hit_wr(tlb_hit_wr),
    .install(install), .install_vpn(va_q[VA_W-1:OFF_W]),
    .install_ppn(mem_rsp_data[26:8]), .install_wr(mem_rsp_data[2]),
    .flush_all(flush_all), .flush_page(flush_page), .flush_vpn(flush_vpn));

  // request decode
  logic [31:0] start, offs;
  logic        byp, in_win;
  assign start  = win_start(win_code);
  assign offs   = req_vaddr - start;
  assign in_win = (req_vaddr >= start);
  assign byp    = slot_bypass[req_slot];

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_addr  = walk_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      kill_q      <= 1'b0;
      walk_addr_q <= '0;
      paddr_q     <= '0;
      fault_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          kill_q  <= 1'b0;
          paddr_q <= '0;
          fault_q <= 1'b0;
          state_q <= S_RESP;
          if (byp) begin
            paddr_q <= {slot_pa30[req_slot], req_vaddr[29:0]};
          end else if (!xl_en || !in_win) begin
            fault_q <= 1'b1;
          end else if (tlb_hit) begin
            if (req_write && !tlb_hit_wr) fault_q <= 1'b1;
            else paddr_q <= {tlb_hit_ppn, req_vaddr[OFF_W-1:0]};
          end else begin
            walk_addr_q <= tbl_base + {10'b0, offs[31:12], 2'b00};
            state_q     <= S_MREQ;
          end
        end
        S_MREQ: begin
          if (flush_all || flush_page) kill_q <= 1'b1;
          if (mem_req_ready) state_q <= S_MWAIT;
        end
        S_MWAIT: begin
          if (flush_all || flush_page) kill_q <= 1'b1;
          if (mem_rsp_valid) begin
            state_q <= S_RESP;
            if (pte_ok) paddr_q <= {mem_rsp_data[26:8], va_q[OFF_W-1:0]};
            else        fault_q <= 1'b1;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
  // R13
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R13
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);
  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);
  // R7
  no_install_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    install |-> mem_rsp_data[1]);
endmodule

// File: tb/test_dma_xlate.sv
`timescale 1ns/1ps
module test_dma_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr_en = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  slot_bypass = 4'b1000, slot_pa30 = 4'b1010;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_slot = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_fault;
  logic [30:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  dma_xlate i_dma_xlate (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  int walk_cnt = 0;
  logic [31:0] walk_addr = 0;
  bit mem_busy = 0, mem_hold = 0;
  int mem_cnt = 0;

  // bench model of configuration and TLB
  bit          m_en = 0;
  logic [2:0]  m_size = 0;
  logic [31:0] m_base = 0;
  logic [19:0] m_vpn [8];
  logic [18:0] m_ppn [8];
  bit          m_wr [8];
  bit          m_v [8];
  int          m_rr = 0;

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    return {5'b0, h[18:0], h[25], 4'b0, h[24], (h[23:21] != 3'b000), 1'b0};
  endfunction

  function automatic logic [31:0] wstart(input logic [2:0] k);
    return 32'hFF00_0000 << k;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: decisions at negedge, seen by the design at next posedge
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (mem_busy) begin
      mem_req_ready = 1'b0;
      if (!mem_hold) begin
        if (mem_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pte_of(walk_addr);
          mem_busy      = 1'b0;
        end else mem_cnt--;
      end
    end else begin
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_ready && mem_req_valid) begin
        mem_busy  = 1'b1;
        mem_cnt   = $urandom % 3;
        walk_cnt++;
        walk_addr = mem_req_addr;
      end
    end
  end

  task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
    if (s == 3'd0) begin m_en = d[0]; m_size = d[4:2]; end
    if (s == 3'd1) m_base = d;
    if (s == 3'd2) for (int i = 0; i < 8; i++) m_v[i] = 0;
    if (s == 3'd3) for (int i = 0; i < 8; i++) if (m_vpn[i] == d[31:12]) m_v[i] = 0;
  endtask

  task automatic send_req(input logic [31:0] va, input logic wr, input logic [1:0] sl);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_slot = sl; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic get_rsp(output logic [30:0] pa, output logic f);
    forever begin
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
      rsp_ready = ($urandom % 3) != 0;
    end
    pa = rsp_paddr; f = rsp_fault;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic do_xact(input logic [31:0] va, input logic wr, input logic [1:0] sl, input string tg = "");
    logic [31:0] st, wa, pte;
    logic [30:0] epa, gpa;
    bit ef = 0, ewalk = 0, inst = 0, gf;
    int hi = -1, w0;
    string tag;
    st = wstart(m_size);
    epa = '0; wa = '0; pte = '0;
    if (slot_bypass[sl]) begin
      tag = "R5"; epa = {slot_pa30[sl], va[29:0]};
    end else if (!m_en) begin
      tag = "R4"; ef = 1;
    end else if (va < st) begin
      tag = "R3"; ef = 1;
    end else begin
      for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == va[31:12]) hi = i;
      if (hi >= 0) begin
        tag = "R8";
        if (wr && !m_wr[hi]) begin ef = 1; tag = "R7"; end
        else epa = {m_ppn[hi], va[11:0]};
      end else begin
        ewalk = 1;
        wa  = m_base + (((va - st) >> 12) << 2);
        pte = pte_of(wa);
        if (!pte[1] || (wr && !pte[2])) begin ef = 1; tag = "R7"; end
        else begin epa = {pte[26:8], va[11:0]}; inst = 1; tag = "R6"; end
      end
    end
    if (tg != "") tag = tg;
    w0 = walk_cnt;
    send_req(va, wr, sl);
    get_rsp(gpa, gf);
    chk(tag, gpa == epa && gf == ef, {32'b0, gf, gpa}, {32'b0, ef, epa});
    chk(tag, (walk_cnt - w0) == int'(ewalk) && (!ewalk || walk_addr == wa),
        {walk_cnt - w0, walk_addr}, {32'(ewalk), wa});
    if (inst) begin
      m_vpn[m_rr] = va[31:12]; m_ppn[m_rr] = pte[26:8];
      m_wr[m_rr] = pte[2]; m_v[m_rr] = 1; m_rr = (m_rr + 1) % 8;
    end
  endtask

  // a page in the 16 MB window whose table entry is usable for reads
  function automatic logic [31:0] good_page(input int from);
    for (int k = from; k < 4096; k++)
      if (pte_of(m_base + (k << 2))[1]) return 32'hFF00_0000 + (k << 12);
    return 32'hFF00_0000;
  endfunction

  initial begin
    logic [31:0] pg [9];
    logic [30:0] gpa;
    logic gf;
    int w0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_wr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 3'd0;
    #0;
    chk("R1", req_ready && !rsp_valid && !mem_req_valid, {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
    @(negedge clk);
    chk("R1", reg_rdata == 32'h1200_0000, reg_rdata, 32'h1200_0000);
    reg_sel = 3'd1; @(negedge clk);
    chk("R1", reg_rdata == 0, reg_rdata, 0);

    // R2 register readback
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_sel = 3'd0; @(negedge clk);
    chk("R2", reg_rdata == 32'h1200_001D, reg_rdata, 32'h1200_001D);
    reg_write(3'd1, 32'h0010_0000);
    reg_sel = 3'd1; @(negedge clk);
    chk("R2", reg_rdata == 32'h0010_0000, reg_rdata, 32'h0010_0000);
    reg_sel = 3'd2; @(negedge clk);
    chk("R2", reg_rdata == 0, reg_rdata, 0);
    reg_sel = 3'd3; @(negedge clk);
    chk("R2", reg_rdata == 0, reg_rdata, 0);

    // R4: disabled
    reg_write(3'd0, 32'h0);
    do_xact(32'hFF00_1234, 0, 2'd0, "R4");
    // R5: bypass regardless of enable, both values of bit 30
    do_xact(32'h4123_4567, 1, 2'd3, "R5");
    slot_pa30 = 4'b0010;
    do_xact(32'hC000_0FFC, 0, 2'd3, "R5");
    slot_pa30 = 4'b1010;

    // R3: window boundaries, 16 MB
    reg_write(3'd0, 32'h1);
    do_xact(32'hFEFF_FFFF, 0, 2'd0, "R3");
    do_xact(32'hFF00_0000, 0, 2'd1, "R6");
    // 2 GB window
    reg_write(3'd0, 32'h1D);
    do_xact(32'h7FFF_FFFF, 0, 2'd2, "R3");
    do_xact(32'h8000_0010, 0, 2'd2, "R6");

    // R9: round robin replacement
    reg_write(3'd0, 32'h1);
    reg_write(3'd2, 32'h0);
    m_rr = m_rr;
    pg[0] = good_page(16);
    for (int i = 1; i < 9; i++) pg[i] = good_page(int'((pg[i-1] - 32'hFF00_0000) >> 12) + 1);
    for (int i = 0; i < 8; i++) do_xact(pg[i] + 32'h44, 0, 2'd0, "R9");
    for (int i = 0; i < 8; i++) do_xact(pg[i] + 32'h88, 0, 2'd1, "R9");
    do_xact(pg[8], 0, 2'd0, "R9");
    do_xact(pg[0], 0, 2'd0, "R9");

    // R7: write to read-only cached entry, and through walks
    for (int i = 0; i < 9; i++) do_xact(pg[i] + 32'h4, 1, 2'd2, "R7");

    // R10: flush all
    reg_write(3'd2, 32'hDEAD_BEEF);
    do_xact(pg[2], 0, 2'd0, "R10");
    do_xact(pg[3], 0, 2'd0, "R10");

    // R11: page flush with nonzero low bits
    reg_write(3'd3, pg[2] | 32'hABC);
    do_xact(pg[3] + 32'h10, 0, 2'd0, "R11");
    do_xact(pg[2] + 32'h10, 0, 2'd0, "R11");

    // R12: flush during an outstanding fetch
    reg_write(3'd2, 0);
    mem_hold = 1;
    w0 = walk_cnt;
    fork
      send_req(pg[5] + 32'h20, 0, 2'd0);
      begin
        wait (walk_cnt == w0 + 1);
        reg_write(3'd2, 0);
        mem_hold = 0;
      end
    join
    get_rsp(gpa, gf);
    chk("R12", !gf && gpa == {pte_of(walk_addr)[26:8], 12'h020}, {32'b0, gf, gpa},
        {32'b0, 1'b0, pte_of(walk_addr)[26:8], 12'h020});
    do_xact(pg[5] + 32'h24, 0, 2'd0, "R12");

    // random traffic mixed with register operations
    for (int it = 0; it < 500; it++) begin
      int r = $urandom % 100;
      if (r < 4) reg_write(3'd2, $urandom);
      else if (r < 10) reg_write(3'd3, {20'hFFFFF - 20'($urandom % 24), 12'($urandom)});
      else if (r < 13) reg_write(3'd0, {27'($urandom), 3'($urandom % 4), 1'b0, ($urandom % 8) != 0});
      else begin
        logic [31:0] va;
        if ($urandom % 8 == 0) va = $urandom;
        else va = {20'hFFFFF - 20'($urandom % 24), 12'($urandom)};
        do_xact(va, $urandom % 2, 2'($urandom % 4), "R13");
      end
    end

    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
  end
endmodule